// File: doc/BRIEF.md
# Partitioned Sub-word SIMD ALU

This block is an integer datapath that treats a 64-bit operand pair as a short vector of narrow elements. A size selector splits the word into eight 8-bit, four 16-bit or two 32-bit elements. Every element is computed in parallel and no carry or borrow ever crosses an element boundary.

The operation set covers several kinds of work:

- wrapping add and subtract;
- saturating add and subtract, with signed or unsigned clamping;
- signed or unsigned minimum and maximum;
- a sum of absolute byte differences that reduces the whole word to one scalar;
- a narrowing pack that turns 16-bit elements of both operands into 8-bit elements with clamping.

The block holds no architectural state besides its output register and signals no exceptions. Overflow is always resolved inside the result word.

The result is registered. Operands and control sampled at a rising clock edge appear on `result` right after that edge. An asynchronous active-low reset clears the output.

Top module: `simd_subword_alu`

## Requirements
- R1: While `rst_n` is low, `result` is zero. Otherwise, inputs sampled at a rising edge of `clk` determine `result` from just after that edge until the next edge.
- R2: `esize` encodings are 0 for 8-bit elements, 1 for 16-bit elements, and 2 or 3 for 32-bit elements. Element i of width W occupies bits [i*W +: W] of the operands and of the result. No carry or borrow propagates from one element into the next.
- R3: `opcode` 0 is a wrapping add and `opcode` 1 is a wrapping subtract (a minus b). Each element result is taken modulo 2^W.
- R4: `opcode` 2 is a saturating add. When `is_signed` is 1, results clamp to 2^(W-1)-1 or -2^(W-1). When `is_signed` is 0, results clamp to all-ones.
- R5: `opcode` 3 is a saturating subtract (a minus b). Signed results clamp as in R4. Unsigned results clamp to zero.
- R6: `opcode` 4 returns the per-element minimum of a and b. The comparison is two's complement when `is_signed` is 1 and unsigned otherwise.
- R7: `opcode` 5 returns the per-element maximum, using the same comparison rule as R6.
- R8: `opcode` 6 returns the sum of the eight unsigned byte absolute differences |a_k - b_k| in bits [15:0], with bits [63:16] zero. `esize` and `is_signed` have no effect on this operation.
- R9: `opcode` 7 packs 16-bit elements into bytes. Element k (k = 0..3) of `op_a` goes to result byte k, and element k of `op_b` goes to result byte 4+k. With `is_signed` = 1, each element is clamped to [-128, 127]. With `is_signed` = 0, each element is read as unsigned and clamped to 255. `esize` has no effect on this operation.
- R10: `is_signed` has no effect on the wrapping add and subtract.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | First operand vector |
| op_b | input | 64 | Second operand vector |
| opcode | input | 3 | Operation select (see R3 to R9) |
| esize | input | 2 | Element width select (see R2) |
| is_signed | input | 1 | Signed interpretation for saturation, compare and pack |
| result | output | 64 | Registered result vector |

## Verification
The bench builds the block with its default 64-bit word. All three element banks and the full eight-byte reduction are therefore exercised exactly as deployed.

At that size the bench runs two kinds of stimulus:

- A full sweep of every first-operand byte against sixteen second-operand bytes, replicated into all lanes. This reaches every signed and unsigned saturation edge of the 8-bit lanes.
- Seeded vectors rich in 0x00, 0x01, 0x7F, 0x80 and 0xFF bytes. These push the 16-bit and 32-bit lanes, the pack clamps and the absolute-difference sum to their limits.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_ADDS = 3'd2,
        OP_SUBS = 3'd3,
        OP_MIN  = 3'd4,
        OP_MAX  = 3'd5,
        OP_SAD  = 3'd6,
        OP_PACK = 3'd7
    } simd_op_e;

    typedef enum logic [1:0] {
        ES_8  = 2'd0,
        ES_16 = 2'd1,
        ES_32 = 2'd2,
        ES_32B = 2'd3
    } simd_size_e;

    localparam int NUM_BANKS = 3;

endpackage

// File: rtl/simd_elem_unit.sv
module simd_elem_unit
    import simd_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  simd_op_e      op,
    input  logic          sgn,
    output logic [EW-1:0] r
);

    localparam logic [EW-1:0] UMAX = {EW{1'b1}};
    localparam logic [EW-1:0] SMAX = {1'b0, {(EW-1){1'b1}}};
    localparam logic [EW-1:0] SMIN = {1'b1, {(EW-1){1'b0}}};

    logic [EW:0]   sum_w;
    logic [EW:0]   dif_w;
    logic          s_add_ovf;
    logic          s_sub_ovf;
    logic          a_lt_b;
    logic [EW-1:0] s_clamp;

    always_comb begin
        sum_w     = {1'b0, a} + {1'b0, b};
        dif_w     = {1'b0, a} - {1'b0, b};
        s_add_ovf = (a[EW-1] == b[EW-1]) && (sum_w[EW-1] != a[EW-1]);
        s_sub_ovf = (a[EW-1] != b[EW-1]) && (dif_w[EW-1] != a[EW-1]);
        s_clamp   = a[EW-1] ? SMIN : SMAX;
        a_lt_b    = sgn ? ($signed(a) < $signed(b)) : (a < b);

        unique case (op)
            OP_ADD:  r = sum_w[EW-1:0];
            OP_SUB:  r = dif_w[EW-1:0];
            OP_ADDS: begin
                if (sgn) r = s_add_ovf ? s_clamp : sum_w[EW-1:0];
                else     r = sum_w[EW] ? UMAX : sum_w[EW-1:0];
            end
            OP_SUBS: begin
                if (sgn) r = s_sub_ovf ? s_clamp : dif_w[EW-1:0];
                else     r = dif_w[EW] ? '0 : dif_w[EW-1:0];
            end
            OP_MIN:  r = a_lt_b ? a : b;
            OP_MAX:  r = a_lt_b ? b : a;
            default: r = sum_w[EW-1:0];
        endcase
    end

endmodule

// File: rtl/simd_sad_unit.sv
module simd_sad_unit #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] r
);

    localparam int NB = DATA_W / 8;
    localparam int SW = $clog2(255 * NB + 1);

    logic [NB-1:0][7:0] absd;
    logic [SW-1:0]      acc;

    genvar gk;
    generate
        for (gk = 0; gk < NB; gk++) begin : g_absd
            logic [7:0] xa;
            logic [7:0] xb;
            assign xa       = a[gk*8 +: 8];
            assign xb       = b[gk*8 +: 8];
            assign absd[gk] = (xa > xb) ? (xa - xb) : (xb - xa);
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int k = 0; k < NB; k++) begin
            acc = acc + SW'(absd[k]);
        end
        r = DATA_W'(acc);
    end

endmodule

// File: rtl/simd_pack_unit.sv
module simd_pack_unit #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sgn,
    output logic [DATA_W-1:0] r
);

    localparam int NH = DATA_W / 16;

    function automatic logic [7:0] narrow(input logic [15:0] v, input logic s);
        logic [7:0] n;
        if (s) begin
            if ($signed(v) > 16'sd127)       n = 8'h7F;
            else if ($signed(v) < -16'sd128) n = 8'h80;
            else                             n = v[7:0];
        end else begin
            n = (v > 16'd255) ? 8'hFF : v[7:0];
        end
        return n;
    endfunction

    genvar gk;
    generate
        for (gk = 0; gk < 2 * NH; gk++) begin : g_byte
            logic [15:0] src;
            if (gk < NH) begin : g_from_a
                assign src = a[gk*16 +: 16];
            end else begin : g_from_b
                assign src = b[(gk-NH)*16 +: 16];
            end
            assign r[gk*8 +: 8] = narrow(src, sgn);
        end
        if (DATA_W > 16 * NH) begin : g_pad
            assign r[DATA_W-1:16*NH] = '0;
        end
    endgenerate

endmodule

// File: rtl/simd_subword_alu.sv
module simd_subword_alu
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [2:0]        opcode,
    input  logic [1:0]        esize,
    input  logic              is_signed,
    output logic [DATA_W-1:0] result
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
    } alu_state_t;

    alu_state_t state_d, state_q;

    simd_op_e                         op_sel;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_r;
    logic [DATA_W-1:0]                sad_r;
    logic [DATA_W-1:0]                pack_r;

    assign op_sel = simd_op_e'(opcode);

    genvar gb, gl;
    generate
        for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            localparam int EW = 8 << gb;
            localparam int NL = DATA_W / EW;
            for (gl = 0; gl < NL; gl++) begin : g_lane
                simd_elem_unit #(.EW(EW)) u_elem (
                    .a   (op_a[gl*EW +: EW]),
                    .b   (op_b[gl*EW +: EW]),
                    .op  (op_sel),
                    .sgn (is_signed),
                    .r   (bank_r[gb][gl*EW +: EW])
                );
            end
        end
    endgenerate

    simd_sad_unit #(.DATA_W(DATA_W)) u_sad (
        .a (op_a),
        .b (op_b),
        .r (sad_r)
    );

    simd_pack_unit #(.DATA_W(DATA_W)) u_pack (
        .a   (op_a),
        .b   (op_b),
        .sgn (is_signed),
        .r   (pack_r)
    );

    always_comb begin
        state_d = state_q;
        unique case (op_sel)
            OP_SAD:  state_d.res = sad_r;
            OP_PACK: state_d.res = pack_r;
            default: begin
                unique case (simd_size_e'(esize))
                    ES_8:    state_d.res = bank_r[0];
                    ES_16:   state_d.res = bank_r[1];
                    default: state_d.res = bank_r[2];
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result = state_q.res;

    // R4
    adds_unsigned_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_ADDS && !is_signed && esize == 2'd0)
        |=> (result[7:0] >= $past(op_a[7:0])) && (result[DATA_W-1 -: 8] >= $past(op_a[DATA_W-1 -: 8])));

    // R6
    min_unsigned_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_MIN && !is_signed && esize == 2'd2)
        |=> (result[31:0] <= $past(op_a[31:0])) && (result[31:0] <= $past(op_b[31:0])));

    // R7
    max_signed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_MAX && is_signed && esize == 2'd1)
        |=> ($signed(result[15:0]) >= $signed($past(op_a[15:0])))
            && ($signed(result[15:0]) >= $signed($past(op_b[15:0]))));

    // R8
    sad_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SAD) |=> (result[DATA_W-1:16] == '0));

    // R9
    pack_unsigned_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_PACK && !is_signed && op_a[15:8] != 8'h00) |=> (result[7:0] == 8'hFF));

endmodule

// File: tb/tb_simd_subword_alu.sv
module tb_simd_subword_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [2:0]  opcode = '0;
    logic [1:0]  esize = '0;
    logic        is_signed = 1'b0;
    logic [63:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;

    always #10 clk = ~clk;

    simd_subword_alu dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .opcode(opcode), .esize(esize), .is_signed(is_signed), .result(result)
    );

    function automatic longint clamp(input longint v, input longint lo, input longint hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input int op, input int es, input bit sg);
        logic [63:0] res = '0;
        int w = (es == 0) ? 8 : ((es == 1) ? 16 : 32);
        longint mask = (longint'(1) << w) - 1;
        longint half = longint'(1) << (w - 1);
        if (op == 6) begin
            longint s = 0;
            for (int k = 0; k < 8; k++) begin
                longint x = longint'((a >> (8*k)) & 64'hFF);
                longint y = longint'((b >> (8*k)) & 64'hFF);
                s += (x > y) ? x - y : y - x;
            end
            return 64'(s);
        end
        if (op == 7) begin
            for (int k = 0; k < 8; k++) begin
                logic [63:0] src = (k < 4) ? a : b;
                longint u = longint'((src >> (16*(k%4))) & 64'hFFFF);
                longint sv = (u >= 32768) ? u - 65536 : u;
                longint n = sg ? (clamp(sv, -128, 127) & 255) : clamp(u, 0, 255);
                res |= 64'(n) << (8*k);
            end
            return res;
        end
        for (int i = 0; i < 64 / w; i++) begin
            longint ua = longint'((a >> (i*w)) & 64'(mask));
            longint ub = longint'((b >> (i*w)) & 64'(mask));
            longint sa = (ua >= half) ? ua - 2*half : ua;
            longint sb = (ub >= half) ? ub - 2*half : ub;
            longint r;
            case (op)
                0: r = ua + ub;
                1: r = ua - ub;
                2: r = sg ? clamp(sa + sb, -half, half - 1) : clamp(ua + ub, 0, mask);
                3: r = sg ? clamp(sa - sb, -half, half - 1) : clamp(ua - ub, 0, mask);
                4: r = sg ? ((sa < sb) ? sa : sb) : ((ua < ub) ? ua : ub);
                default: r = sg ? ((sa > sb) ? sa : sb) : ((ua > ub) ? ua : ub);
            endcase
            res |= 64'(r & mask) << (i*w);
        end
        return res;
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0, 1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s op=%0d es=%0d sg=%0d a=%h b=%h actual=%h expected=%h",
                     tag, opcode, esize, is_signed, op_a, op_b, got, exp);
        end
    endtask

    task automatic run(input logic [63:0] a, input logic [63:0] b, input int op,
                       input int es, input bit sg, input string tag);
        @(negedge clk);
        op_a = a; op_b = b; opcode = 3'(op); esize = 2'(es); is_signed = sg;
        @(posedge clk);
        #2;
        check(tag, result, model(a, b, op, es, sg));
    endtask

    function automatic logic [63:0] next_rand();
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        return seed ^ (seed >> 29);
    endfunction

    function automatic logic [63:0] corner_word(input logic [63:0] r);
        logic [63:0] w = '0;
        for (int k = 0; k < 8; k++) begin
            case ((r >> (3*k)) & 64'h7)
                0: w[8*k +: 8] = 8'h00;
                1: w[8*k +: 8] = 8'h7F;
                2: w[8*k +: 8] = 8'h80;
                3: w[8*k +: 8] = 8'hFF;
                4: w[8*k +: 8] = 8'h01;
                default: w[8*k +: 8] = r[8*k +: 8] ^ 8'h5A;
            endcase
        end
        return w;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset holds result at zero even with live inputs
        op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'h1; opcode = 3'd0;
        repeat (3) @(posedge clk);
        #2;
        check("R1", result, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: lane carries stop at each boundary
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 0, 1'b0, "R2");
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 0, 1, 1'b0, "R2");
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 0, 3, 1'b0, "R2");
        run(64'h0, 64'h0101_0101_0101_0101, 1, 0, 1'b0, "R2");

        // R10: wrapping ops give identical results for either signedness
        for (int i = 0; i < 200; i++) begin
            logic [63:0] a = next_rand();
            logic [63:0] b = corner_word(next_rand());
            for (int s = 0; s < 2; s++) begin
                run(a, b, i % 2, i % 4, s[0], "R10");
            end
        end

        // R4 R5: every 8-bit a against sixteen b values, replicated in all lanes
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y += 17) begin
                logic [63:0] a = {8{8'(x)}};
                logic [63:0] b = {8{8'(y)}};
                for (int op = 2; op < 4; op++) begin
                    for (int s = 0; s < 2; s++) begin
                        run(a, b, op, 0, s[0], tag_of(op));
                    end
                end
            end
        end

        // All ops, sizes and signedness over seeded and corner-heavy vectors
        for (int op = 0; op < 8; op++) begin
            for (int es = 0; es < 4; es++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int i = 0; i < 150; i++) begin
                        logic [63:0] a = (i % 3 == 0) ? corner_word(next_rand()) : next_rand();
                        logic [63:0] b = (i % 2 == 0) ? corner_word(next_rand()) : next_rand();
                        run(a, b, op, es, s[0], tag_of(op));
                    end
                end
            end
        end

        // R8: extreme sum with all bytes differing by 255
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6, 2, 1'b1, "R8");
        // R9: explicit clamp edges in both signedness modes
        run(64'h7FFF_FF80_0080_007F, 64'h8000_FF7F_0100_00FF, 7, 0, 1'b1, "R9");
        run(64'h7FFF_FF80_0080_007F, 64'h8000_FF7F_0100_00FF, 7, 2, 1'b0, "R9");

        finish_run();
    end

endmodule